// File: doc/BRIEF.md
# Display Channel Enable and Reset Controller

This block holds the control and status logic for one output channel of a display compositor. Software programs a control word to set the active width and height, arm the channel, choose single-frame operation, or flush it. It reads back a status word that gives the operating mode, the output FIFO full and empty flags, and a count of completed frames. Once armed, the channel does not produce output straight away. It waits for a vertical-start strobe and then composes one frame, which ends once width × height pixels have entered the output FIFO. Pixels move into the FIFO on push strobes and leave it on pop strobes. The block keeps only the occupancy of that FIFO, not the pixel data.

In continuous operation the channel re-arms after each frame and waits for the next vertical start. In single-frame operation, used when the output feeds a writeback sink, it stops after one frame and holds until software drops the enable. A flush command empties the FIFO and returns the channel to the disabled mode. It takes a fixed number of clocks, and the flush bit reads as set while it runs, so software can poll the flush bit and the mode field to confirm that shutdown has finished.

The internal states are IDLE, ARM, COMPOSE, HOLD and FLUSH. The transitions are:
- IDLE→ARM when enable is set.
- ARM→COMPOSE on vertical start.
- COMPOSE→ARM at the end of a frame in continuous operation.
- COMPOSE→HOLD at the end of a frame in single-frame operation.
- ARM, COMPOSE or HOLD→IDLE when enable is cleared.
- Any state other than FLUSH→FLUSH on a flush write.
- FLUSH→IDLE after the fixed flush length.

Top module: `dchan_ctrl`

## Requirements
- R1: After reset the status word reads mode 0 (DISABLED), empty (status bit 3) set, full (status bit 2) clear and frame count 0, and the control word reads 0. Register address 0 is control and address 1 is status.
- R2: Once enable (control bit 0) has been stored, the mode becomes 1 (WAIT_VSTART) one clock later and stays there until a vertical start. Push strobes outside mode 2 are ignored, so the FIFO stays empty.
- R3: A vertical-start strobe in mode 1 moves the mode to 2 (RUNNING) on the next clock, and mode 2 is entered from no other mode.
- R4: A frame ends on the accepted push that brings the pixel count to width (control bits 15:4) × height (control bits 27:16). With single-frame operation off, the mode then returns to 1. The control word reads back the stored width, height and flags.
- R5: With single-frame operation on (control bit 2), the frame end moves the mode to 3 (ONESHOT_DONE). The channel stays in mode 3, ignoring vertical start and pushes, until enable is cleared.
- R6: The FIFO model has depth 8. A push is accepted only in mode 2 while the FIFO is not full, and a pop is accepted only while it is not empty. A push refused because the FIFO is full is not counted as a pixel.
- R7: Writing control bit 1 starts a flush that lasts 4 clocks. During the flush, control bit 1 reads 1 and the mode reads 0. When the flush ends, bit 1 reads 0, the FIFO reads empty and not full, and the mode is 0.
- R8: Control writes made while a flush is running are ignored.
- R9: The frame count (status bits 9:4) is 6 bits wide, increments by one at each frame end and wraps from 63 to 0.
- R10: Clearing enable in mode 1, 2 or 3 returns the mode to 0 one clock after the write is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected address (combinational) |
| vstart | input | 1 | Vertical-start strobe |
| pix_push | input | 1 | Strobe: one composed pixel enters the FIFO |
| pix_pop | input | 1 | Strobe: one pixel leaves the FIFO |

## Verification
The main function is tried with four patterns:
- Frames of four pixels in continuous operation. These separate the correct end-of-frame point from an off-by-one, because the mode must still be running after three pushes.
- A long frame driven past a full FIFO. This separates refused pushes from counted ones, and shows whether a surplus pop underflows the occupancy.
- Single-frame operation followed by extra vertical starts and pushes. This separates the stop-and-hold behaviour from an automatic re-arm.
- Sixty-two one-pixel frames. These carry the frame count across its wrap.

A flush is issued with the FIFO partly full and a write is attempted during it. This separates the self-clearing flush bit, the FIFO clearing and the write blocking from one another.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

    localparam int DIM_W       = 12;
    localparam int REG_W       = 32;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_FL_BIT  = 1;
    localparam int CTL_ONE_BIT = 2;
    localparam int CTL_W_LSB   = 4;
    localparam int CTL_H_LSB   = 16;

    localparam int ST_FULL_BIT  = 2;
    localparam int ST_EMPTY_BIT = 3;
    localparam int ST_FRM_LSB   = 4;

    typedef enum logic [1:0] {
        MODE_OFF         = 2'd0,
        MODE_ARMED       = 2'd1,
        MODE_ACTIVE      = 2'd2,
        MODE_SINGLE_DONE = 2'd3
    } chan_mode_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_ARM     = 3'd1,
        S_COMPOSE = 3'd2,
        S_HOLD    = 3'd3,
        S_FLUSH   = 3'd4
    } chan_state_e;

    typedef struct packed {
        logic             en;
        logic             oneshot;
        logic [DIM_W-1:0] width;
        logic [DIM_W-1:0] height;
    } chan_ctl_t;

endpackage

// File: rtl/dchan_regs.sv
module dchan_regs
    import dchan_pkg::*;
#(
    parameter int FRAME_CNT_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic                   addr,
    input  logic [REG_W-1:0]       wdata,
    input  logic                   busy,
    input  chan_mode_e             mode,
    input  logic                   full,
    input  logic                   empty,
    input  logic [FRAME_CNT_W-1:0] frame_cnt,
    output logic [REG_W-1:0]       rdata,
    output chan_ctl_t              ctl,
    output logic                   flush_req
);

    logic wr_ctl;

    // Control writes are blocked while a flush is running.
    assign wr_ctl    = we && (addr == 1'b0) && !busy;
    assign flush_req = wr_ctl && wdata[CTL_FL_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_ctl) begin
            ctl.en      <= wdata[CTL_EN_BIT];
            ctl.oneshot <= wdata[CTL_ONE_BIT];
            ctl.width   <= wdata[CTL_W_LSB +: DIM_W];
            ctl.height  <= wdata[CTL_H_LSB +: DIM_W];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == 1'b0) begin
            rdata[CTL_EN_BIT]           = ctl.en;
            rdata[CTL_FL_BIT]           = busy;
            rdata[CTL_ONE_BIT]          = ctl.oneshot;
            rdata[CTL_W_LSB +: DIM_W]   = ctl.width;
            rdata[CTL_H_LSB +: DIM_W]   = ctl.height;
        end else begin
            rdata[1:0]                       = mode;
            rdata[ST_FULL_BIT]               = full;
            rdata[ST_EMPTY_BIT]              = empty;
            rdata[ST_FRM_LSB +: FRAME_CNT_W] = frame_cnt;
        end
    end

endmodule

// File: rtl/dchan_fifo_level.sv
module dchan_fifo_level #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic push,
    input  logic pop,
    input  logic allow_push,
    input  logic allow_pop,
    output logic push_acc,
    output logic full,
    output logic empty
);

    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [OCC_W-1:0] occ;
    logic             pop_acc;

    assign full     = (occ == OCC_W'(DEPTH));
    assign empty    = (occ == '0);
    assign push_acc = push && allow_push && !full;
    assign pop_acc  = pop  && allow_pop  && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            occ <= '0;
        else if (clear)
            occ <= '0;
        else
            occ <= occ + OCC_W'(push_acc) - OCC_W'(pop_acc);
    end

endmodule

// File: rtl/dchan_fsm.sv
module dchan_fsm
    import dchan_pkg::*;
#(
    parameter int FLUSH_CYCLES = 4,
    parameter int FRAME_CNT_W  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  chan_ctl_t              ctl,
    input  logic                   flush_req,
    input  logic                   vstart,
    input  logic                   pix_acc,
    output chan_mode_e             mode,
    output logic                   running,
    output logic                   in_flush,
    output logic                   frame_end,
    output logic [FRAME_CNT_W-1:0] frame_cnt
);

    localparam int AREA_W = 2 * DIM_W;
    localparam int FL_W   = $clog2(FLUSH_CYCLES + 1);

    chan_state_e       state, nxt;
    logic [FL_W-1:0]   fl_cnt;
    logic [AREA_W-1:0] pix_cnt;
    logic [AREA_W-1:0] area;

    assign area      = ctl.width * ctl.height;
    assign frame_end = (state == S_COMPOSE) && pix_acc
                       && ((pix_cnt + AREA_W'(1)) == area);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (ctl.en) nxt = S_ARM;
            S_ARM: begin
                if (!ctl.en)     nxt = S_IDLE;
                else if (vstart) nxt = S_COMPOSE;
            end
            S_COMPOSE: begin
                if (!ctl.en)        nxt = S_IDLE;
                else if (frame_end) nxt = ctl.oneshot ? S_HOLD : S_ARM;
            end
            S_HOLD:    if (!ctl.en) nxt = S_IDLE;
            S_FLUSH:   if (fl_cnt == FL_W'(FLUSH_CYCLES - 1)) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
        if (flush_req) nxt = S_FLUSH;
    end

    // Outputs decoded from the state.
    always_comb begin
        running  = 1'b0;
        in_flush = 1'b0;
        unique case (state)
            S_IDLE:    mode = MODE_OFF;
            S_ARM:     mode = MODE_ARMED;
            S_COMPOSE: begin mode = MODE_ACTIVE; running = 1'b1; end
            S_HOLD:    mode = MODE_SINGLE_DONE;
            S_FLUSH:   begin mode = MODE_OFF; in_flush = 1'b1; end
            default:   mode = MODE_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                fl_cnt <= '0;
        else if (state == S_FLUSH) fl_cnt <= fl_cnt + FL_W'(1);
        else                       fl_cnt <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pix_cnt <= '0;
        else if (state != S_COMPOSE) pix_cnt <= '0;
        else if (frame_end)          pix_cnt <= '0;
        else if (pix_acc)            pix_cnt <= pix_cnt + AREA_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         frame_cnt <= '0;
        else if (frame_end) frame_cnt <= frame_cnt + FRAME_CNT_W'(1);
    end

endmodule

// File: rtl/dchan_ctrl.sv
module dchan_ctrl
    import dchan_pkg::*;
#(
    parameter int FIFO_DEPTH   = 8,
    parameter int FLUSH_CYCLES = 4,
    parameter int FRAME_CNT_W  = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        vstart,
    input  logic        pix_push,
    input  logic        pix_pop
);

    chan_ctl_t              ctl;
    chan_mode_e             mode;
    logic                   flush_req;
    logic                   in_flush;
    logic                   running;
    logic                   frame_end;
    logic                   pix_acc;
    logic                   fifo_full;
    logic                   fifo_empty;
    logic [FRAME_CNT_W-1:0] frame_cnt;

    dchan_regs #(.FRAME_CNT_W(FRAME_CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .busy      (in_flush),
        .mode      (mode),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .frame_cnt (frame_cnt),
        .rdata     (reg_rdata),
        .ctl       (ctl),
        .flush_req (flush_req)
    );

    dchan_fsm #(.FLUSH_CYCLES(FLUSH_CYCLES), .FRAME_CNT_W(FRAME_CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .flush_req (flush_req),
        .vstart    (vstart),
        .pix_acc   (pix_acc),
        .mode      (mode),
        .running   (running),
        .in_flush  (in_flush),
        .frame_end (frame_end),
        .frame_cnt (frame_cnt)
    );

    dchan_fifo_level #(.DEPTH(FIFO_DEPTH)) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (flush_req || in_flush),
        .push       (pix_push),
        .pop        (pix_pop),
        .allow_push (running),
        .allow_pop  (!in_flush),
        .push_acc   (pix_acc),
        .full       (fifo_full),
        .empty      (fifo_empty)
    );

endmodule

// File: rtl/dchan_ctrl_chk.sv
module dchan_ctrl_chk #(
    parameter int FLUSH_CYCLES = 4,
    parameter int FRAME_CNT_W  = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   vstart,
    input logic                   in_flush,
    input logic                   fifo_full,
    input logic                   fifo_empty,
    input logic [1:0]             mode,
    input logic                   ctl_os,
    input logic [FRAME_CNT_W-1:0] frame_cnt
);

    localparam int LEN_W = $clog2(FLUSH_CYCLES + 2) + 1;

    logic [LEN_W-1:0] fl_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        fl_len <= '0;
        else if (in_flush) fl_len <= fl_len + LEN_W'(1);
        else               fl_len <= '0;
    end

    // R7: the flush lasts exactly FLUSH_CYCLES clocks
    assert_flush_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_flush) |-> (fl_len == LEN_W'(FLUSH_CYCLES)));

    // R7: after a flush the FIFO is empty and the mode is disabled
    assert_flush_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_flush) |-> (fifo_empty && !fifo_full && mode == 2'd0));

    // R6: full and empty are never reported together
    assert_full_empty_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R3: running is entered only from waiting with a vertical start, or held
    assert_run_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && $past(mode) != 2'd2) |-> ($past(mode) == 2'd1 && $past(vstart)));

    // R5: the single-frame done mode is entered only from running with oneshot set
    assert_done_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && $past(mode) != 2'd3) |-> ($past(mode) == 2'd2 && $past(ctl_os)));

    // R9: the frame count moves only by one, from running, and wraps
    assert_frame_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt != $past(frame_cnt)) |->
            (frame_cnt == $past(frame_cnt) + 1'b1 && $past(mode) == 2'd2));

endmodule

bind dchan_ctrl dchan_ctrl_chk #(
    .FLUSH_CYCLES (FLUSH_CYCLES),
    .FRAME_CNT_W  (FRAME_CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vstart     (vstart),
    .in_flush   (in_flush),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .mode       (mode),
    .ctl_os     (ctl.oneshot),
    .frame_cnt  (frame_cnt)
);

// File: tb/dchan_ctrl_tb.sv
module dchan_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        vstart = 1'b0;
    logic        pix_push = 1'b0;
    logic        pix_pop = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dchan_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .vstart    (vstart),
        .pix_push  (pix_push),
        .pix_pop   (pix_pop)
    );

    function automatic logic [31:0] ctl_word(input logic en, input logic fl,
                                             input logic os, input int w, input int h);
        return {4'b0, h[11:0], w[11:0], 1'b0, os, fl, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [31:0] d);
        reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic strobe(input logic vs, input logic pu, input logic po, input int n);
        for (int i = 0; i < n; i++) begin
            vstart = vs; pix_push = pu; pix_pop = po;
            @(negedge clk);
            vstart = 1'b0; pix_push = 1'b0; pix_pop = 1'b0;
        end
    endtask

    // status fields: mode[1:0], full bit 2, empty bit 3, frame[9:4]
    task automatic chk_status(input string req, input int mode, input logic full,
                              input logic empty, input int frame);
        logic [31:0] d;
        rd(1'b1, d);
        chk({req, " mode"},  {30'b0, d[1:0]}, mode);
        chk({req, " full"},  {31'b0, d[2]}, {31'b0, full});
        chk({req, " empty"}, {31'b0, d[3]}, {31'b0, empty});
        chk({req, " frame"}, {26'b0, d[9:4]}, frame);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk_status("R1 reset", 0, 1'b0, 1'b1, 0);
        rd(1'b0, d);
        chk("R1 ctrl after reset", d, 32'h0);
    endtask

    task automatic t_continuous;
        logic [31:0] d;
        wr_ctl(ctl_word(1'b1, 1'b0, 1'b0, 2, 2));
        rd(1'b0, d);
        chk("R4 ctrl readback", d, 32'h0002_0021);
        idle(1);
        chk_status("R2 armed", 1, 1'b0, 1'b1, 0);
        strobe(1'b0, 1'b1, 1'b0, 3);
        chk_status("R2 push ignored while armed", 1, 1'b0, 1'b1, 0);
        strobe(1'b1, 1'b0, 1'b0, 1);
        chk_status("R3 vstart starts frame", 2, 1'b0, 1'b1, 0);
        strobe(1'b0, 1'b1, 1'b0, 3);
        chk_status("R4 frame not ended early", 2, 1'b0, 1'b0, 0);
        strobe(1'b0, 1'b1, 1'b0, 1);
        chk_status("R4 frame end rearms", 1, 1'b0, 1'b0, 1);
    endtask

    task automatic t_full;
        logic [31:0] d;
        wr_ctl(ctl_word(1'b1, 1'b0, 1'b0, 100, 1));
        rd(1'b0, d);
        chk("R4 ctrl readback wide", d, 32'h0001_0641);
        strobe(1'b1, 1'b0, 1'b0, 1);
        strobe(1'b0, 1'b1, 1'b0, 10);
        chk_status("R6 fifo full", 2, 1'b1, 1'b0, 1);
        strobe(1'b0, 1'b0, 1'b1, 8);
        chk_status("R6 drained", 2, 1'b0, 1'b1, 1);
        strobe(1'b0, 1'b0, 1'b1, 2);
        strobe(1'b0, 1'b1, 1'b0, 1);
        chk_status("R6 no underflow", 2, 1'b0, 1'b0, 1);
    endtask

    task automatic t_flush;
        logic [31:0] d;
        strobe(1'b0, 1'b1, 1'b0, 2);
        wr_ctl(ctl_word(1'b0, 1'b1, 1'b0, 100, 1));
        rd(1'b0, d);
        chk("R7 flush bit set", {31'b0, d[1]}, 32'd1);
        chk_status("R7 during flush", 0, 1'b0, 1'b1, 1);
        wr_ctl(ctl_word(1'b1, 1'b0, 1'b0, 5, 5));
        idle(2);
        rd(1'b0, d);
        chk("R7 flush bit last cycle", {31'b0, d[1]}, 32'd1);
        idle(1);
        rd(1'b0, d);
        chk("R7 flush bit self-clears", {31'b0, d[1]}, 32'd0);
        idle(2);
        rd(1'b0, d);
        chk("R8 write during flush ignored", d, 32'h0001_0640);
        chk_status("R7 after flush", 0, 1'b0, 1'b1, 1);
    endtask

    task automatic t_oneshot;
        wr_ctl(ctl_word(1'b1, 1'b0, 1'b1, 1, 3));
        idle(1);
        strobe(1'b1, 1'b0, 1'b0, 1);
        strobe(1'b0, 1'b1, 1'b0, 3);
        chk_status("R5 oneshot done", 3, 1'b0, 1'b0, 2);
        strobe(1'b0, 1'b0, 1'b1, 3);
        strobe(1'b1, 1'b0, 1'b0, 1);
        strobe(1'b0, 1'b1, 1'b0, 2);
        chk_status("R5 done holds", 3, 1'b0, 1'b1, 2);
        wr_ctl(ctl_word(1'b0, 1'b0, 1'b1, 1, 3));
        idle(1);
        chk_status("R10 disable returns off", 0, 1'b0, 1'b1, 2);
    endtask

    task automatic t_wrap;
        wr_ctl(ctl_word(1'b1, 1'b0, 1'b0, 1, 1));
        idle(1);
        for (int f = 0; f < 61; f++) begin
            strobe(1'b1, 1'b0, 1'b0, 1);
            strobe(1'b0, 1'b1, 1'b0, 1);
            strobe(1'b0, 1'b0, 1'b1, 1);
        end
        chk_status("R9 count at 63", 1, 1'b0, 1'b1, 63);
        strobe(1'b1, 1'b0, 1'b0, 1);
        strobe(1'b0, 1'b1, 1'b0, 1);
        chk_status("R9 count wraps", 1, 1'b0, 1'b0, 0);
        strobe(1'b1, 1'b0, 1'b0, 1);
        wr_ctl(ctl_word(1'b0, 1'b0, 1'b0, 1, 1));
        idle(1);
        chk_status("R10 disable from running", 0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_continuous();
        t_full();
        t_flush();
        t_oneshot();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule